// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block turns one board-level reset pin and several in-band reset events into two reset outputs, each timed to its own clock. The host bus interface unit gets a level reset. It is forced low as soon as the active-low pin drops and stays low for as long as the pin stays low. Every other unit in the controller shares one core reset. That reset also goes low while the pin is low. Its main job, though, is to fire for a fixed stretch on four triggers: the pin's release edge, a low-power exit indication, a hot-reset message strobe, and the link falling back into a training state.

The pin is asynchronous, so it is brought into each clock domain through its own synchronizer chain. A reset is asserted asynchronously and released synchronously. The in-band inputs are sampled on the core clock, and a trigger is taken on their rising edge. Triggers that overlap, or that arrive during a stretch, merge into one core reset pulse, and the count restarts each time. A sticky cause register records every source that fired. Software clears it by writing ones.

Top module: `rst_fanout_ctrl`

## Requirements
- R1: `bus_rst_n` goes low at once, with no clock edge needed, whenever `fund_rst_n` is low, and it stays low for as long as the pin stays low.
- R2: After `fund_rst_n` rises, `bus_rst_n` rises on the second rising `bus_clk` edge. No in-band event ever pulls it low.
- R3: `core_rst_n` goes low at once whenever `fund_rst_n` is low, and it stays low for as long as the pin stays low.
- R4: After `fund_rst_n` rises, `core_rst_n` stays low for 18 rising `core_clk` edges and is high after the 19th. This is two synchronizer stages, one edge-detect stage and 16 stretch cycles.
- R5: A rising edge on `hot_rst_msg` that is sampled at core edge k drives `core_rst_n` low after edge k. It stays low through edge k+15 and is high again after edge k+16, which gives exactly 16 cycles.
- R6: A rising edge on `pwr_exit` produces the same 16-cycle core reset as R5.
- R7: `link_state` uses these codes: 4'h1 is Detect and 4'h2 is Polling. A reset fires only when the state moves from a code outside that pair to a code inside it. Staying in the pair does not fire one, and neither does moving between Detect and Polling.
- R8: A new trigger while a stretch is running restarts the full 16-cycle count. Triggers in the same cycle produce a single stretch.
- R9: `rst_cause` bits are: bit 0 for pin release, bit 1 for power-state exit, bit 2 for hot-reset message, and bit 3 for link down. A bit is set on the edge that samples its trigger. It stays set until it is cleared, and all sources that fire in the same cycle are recorded.
- R10: While `cause_clr_we` is high, each 1 in `cause_clr_mask` clears the matching cause bit on the next core edge, and 0 bits leave their cause bits unchanged. A trigger in the same cycle as a clear wins, so its bit ends up set.
- R11: `rst_cause` is zero while the pin is asserted. In-band events that arrive before the synchronized release are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Clock for the core reset, the in-band inputs and the cause register |
| bus_clk | input | 1 | Clock for the bus interface reset |
| fund_rst_n | input | 1 | Asynchronous active-low fundamental reset pin |
| pwr_exit | input | 1 | Low-power exit indication; its rising edge triggers a reset |
| hot_rst_msg | input | 1 | Hot-reset message strobe from the physical layer |
| link_state | input | 4 | Current link training state code |
| cause_clr_we | input | 1 | Write enable for clearing cause bits |
| cause_clr_mask | input | 4 | Write-1-to-clear mask for the cause bits |
| bus_rst_n | output | 1 | Level reset for the bus interface unit, active low |
| core_rst_n | output | 1 | Stretched reset for all other units, active low |
| rst_cause | output | 4 | Sticky record of the reset sources that fired |

## Verification
Three situations are hard to reach from the ports:
- A trigger that lands in the middle of a stretch, where the only visible sign is that the release comes later. The stimulus fires a second source ten cycles into a running stretch and then counts the cycles to the new release.
- A clear that collides with a new trigger in the same cycle. The stimulus drives the strobe and the clear mask on the same edge.
- An in-band event that arrives while the pin is still held. The stimulus pulses the hot-reset strobe while the pin is low, then releases the pin and reads the cause register.

// File: rtl/rst_fanout_pkg.sv
package rst_fanout_pkg;
   localparam int CAUSE_W  = 4;
   localparam int N_STROBE = 2;

   typedef enum int {
      CZ_PIN  = 0,
      CZ_PWR  = 1,
      CZ_HOT  = 2,
      CZ_LINK = 3
   } cause_idx_e;

   typedef logic [CAUSE_W-1:0] cause_vec_t;
endpackage

// File: rtl/rst_sync_chain.sv
// Reset synchronizer: asynchronous assertion, release after STAGES clock edges.
module rst_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic out_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rst_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign out_n = chain_q[STAGES-1];
endmodule

// File: rtl/rst_event_detect.sv
// Edge detection for the pin, the strobe inputs and link-down entry.
module rst_event_detect #(
   parameter int              N_STROBE   = 2,
   parameter int              LTS_W      = 4,
   parameter logic [LTS_W-1:0] LTS_POLL   = 4'h2,
   parameter logic [LTS_W-1:0] LTS_DETECT = 4'h1
) (
   input  logic                clk,
   input  logic                arst_n,
   input  logic                pin_sync_i,
   input  logic [N_STROBE-1:0] strobe_i,
   input  logic [LTS_W-1:0]    lts_i,
   output logic                pin_rise_o,
   output logic [N_STROBE-1:0] strobe_fire_o,
   output logic                link_fire_o
);
   logic                pin_q;
   logic [N_STROBE-1:0] strobe_q;
   logic                in_pd_q;
   logic                in_pd;

   assign in_pd = (lts_i == LTS_POLL) || (lts_i == LTS_DETECT);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         pin_q    <= 1'b0;
         strobe_q <= '0;
         in_pd_q  <= 1'b1;
      end else begin
         pin_q    <= pin_sync_i;
         strobe_q <= strobe_i;
         in_pd_q  <= in_pd;
      end
   end

   assign pin_rise_o  = pin_sync_i & ~pin_q;
   assign link_fire_o = pin_sync_i & in_pd & ~in_pd_q;

   for (genvar i = 0; i < N_STROBE; i++) begin : g_strobe
      assign strobe_fire_o[i] = pin_sync_i & strobe_i[i] & ~strobe_q[i];
   end

   // R7: a link-down trigger cannot repeat on the following cycle
   assert_link_once_R7: assert property (@(posedge clk) disable iff (!arst_n)
      link_fire_o |=> !link_fire_o);
endmodule

// File: rtl/rst_stretch.sv
// Holds the core reset for STRETCH cycles after the latest trigger.
module rst_stretch #(
   parameter int STRETCH = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic hold_i,
   input  logic trig_i,
   output logic rst_n_o
);
   if (STRETCH < 1) begin : g_bad_stretch
      $error("rst_stretch: STRETCH must be at least 1");
   end

   localparam int CNT_W = $clog2(STRETCH + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             rst_n_q;

   always_comb begin
      if (hold_i || trig_i)  cnt_d = CNT_LOAD;
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
      else                   cnt_d = '0;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q   <= CNT_LOAD;
         rst_n_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         rst_n_q <= (cnt_d == '0);
      end
   end

   assign rst_n_o = rst_n_q;

   // R5: a trigger pulls the core reset low on the next edge
   assert_trig_low_R5: assert property (@(posedge clk) disable iff (!arst_n)
      trig_i |=> !rst_n_o);
   // R4: without a new trigger the count falls by one each cycle
   assert_count_down_R4: assert property (@(posedge clk) disable iff (!arst_n)
      (!hold_i && !trig_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   // R8: release happens only when the count runs out
   assert_release_R8: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n_o) |-> ($past(cnt_q) == CNT_W'(1)));
endmodule

// File: rtl/rst_cause_reg.sv
// Sticky record of reset sources, write-one-to-clear, set beats clear.
module rst_cause_reg
   import rst_fanout_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic       hold_i,
   input  cause_vec_t fired_i,
   input  logic       clr_we_i,
   input  cause_vec_t clr_mask_i,
   output cause_vec_t cause_o
);
   cause_vec_t cause_q;
   cause_vec_t clr_eff;

   assign clr_eff = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     cause_q <= '0;
      else if (hold_i) cause_q <= '0;
      else             cause_q <= (cause_q & ~clr_eff) | fired_i;
   end

   assign cause_o = cause_q;

   // R9: every source that fired is recorded
   assert_set_R9: assert property (@(posedge clk) disable iff (!arst_n)
      (fired_i != '0) |=> ((cause_o & $past(fired_i)) == $past(fired_i)));
   // R10: bits stay set when no clear is written
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!arst_n)
      (!clr_we_i && !hold_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
   // R11: held at zero until the pin release is seen
   assert_hold_zero_R11: assert property (@(posedge clk) disable iff (!arst_n)
      hold_i |=> (cause_o == '0));
endmodule

// File: rtl/rst_fanout_ctrl.sv
module rst_fanout_ctrl
   import rst_fanout_pkg::*;
#(
   parameter int               SYNC_STAGES    = 2,
   parameter int               STRETCH_CYCLES = 16,
   parameter int               LTS_W          = 4,
   parameter logic [LTS_W-1:0] LTS_POLL       = 4'h2,
   parameter logic [LTS_W-1:0] LTS_DETECT     = 4'h1
) (
   input  logic             core_clk,
   input  logic             bus_clk,
   input  logic             fund_rst_n,
   input  logic             pwr_exit,
   input  logic             hot_rst_msg,
   input  logic [LTS_W-1:0] link_state,
   input  logic             cause_clr_we,
   input  logic [3:0]       cause_clr_mask,
   output logic             bus_rst_n,
   output logic             core_rst_n,
   output logic [3:0]       rst_cause
);
   if (LTS_POLL == LTS_DETECT) begin : g_bad_codes
      $error("rst_fanout_ctrl: training state codes must differ");
   end
   if (CAUSE_W != 4) begin : g_bad_cause
      $error("rst_fanout_ctrl: cause width must be 4");
   end

   logic                pin_sync;
   logic                pin_rise;
   logic [N_STROBE-1:0] strobe_vec;
   logic [N_STROBE-1:0] strobe_fire;
   logic                link_fire;
   cause_vec_t          fired;

   // bus interface domain: level reset straight from the pin
   rst_sync_chain #(.STAGES(SYNC_STAGES)) u_bus_sync (
      .clk    (bus_clk),
      .arst_n (fund_rst_n),
      .out_n  (bus_rst_n)
   );

   // core domain copy of the pin
   rst_sync_chain #(.STAGES(SYNC_STAGES)) u_core_sync (
      .clk    (core_clk),
      .arst_n (fund_rst_n),
      .out_n  (pin_sync)
   );

   assign strobe_vec = {hot_rst_msg, pwr_exit};

   rst_event_detect #(
      .N_STROBE   (N_STROBE),
      .LTS_W      (LTS_W),
      .LTS_POLL   (LTS_POLL),
      .LTS_DETECT (LTS_DETECT)
   ) u_detect (
      .clk           (core_clk),
      .arst_n        (fund_rst_n),
      .pin_sync_i    (pin_sync),
      .strobe_i      (strobe_vec),
      .lts_i         (link_state),
      .pin_rise_o    (pin_rise),
      .strobe_fire_o (strobe_fire),
      .link_fire_o   (link_fire)
   );

   always_comb begin
      fired          = '0;
      fired[CZ_PIN]  = pin_rise;
      fired[CZ_PWR]  = strobe_fire[0];
      fired[CZ_HOT]  = strobe_fire[1];
      fired[CZ_LINK] = link_fire;
   end

   rst_stretch #(.STRETCH(STRETCH_CYCLES)) u_stretch (
      .clk     (core_clk),
      .arst_n  (fund_rst_n),
      .hold_i  (~pin_sync),
      .trig_i  (|fired),
      .rst_n_o (core_rst_n)
   );

   rst_cause_reg u_cause (
      .clk        (core_clk),
      .arst_n     (fund_rst_n),
      .hold_i     (~pin_sync),
      .fired_i    (fired),
      .clr_we_i   (cause_clr_we),
      .clr_mask_i (cause_clr_mask),
      .cause_o    (rst_cause)
   );

   // R1: bus interface held while the pin is low
   assert_bus_hold_R1: assert property (@(posedge bus_clk)
      !fund_rst_n |-> !bus_rst_n);
   // R3: core units held while the pin is low
   assert_core_hold_R3: assert property (@(posedge core_clk)
      !fund_rst_n |-> !core_rst_n);
endmodule

// File: tb/rst_fanout_ctrl_bench.sv
module rst_fanout_ctrl_bench;
   logic       core_clk = 1'b0;
   logic       bus_clk  = 1'b0;
   logic       fund_rst_n = 1'b0;
   logic       pwr_exit = 1'b0;
   logic       hot_rst_msg = 1'b0;
   logic [3:0] link_state = 4'h7;
   logic       cause_clr_we = 1'b0;
   logic [3:0] cause_clr_mask = 4'h0;
   logic       bus_rst_n;
   logic       core_rst_n;
   logic [3:0] rst_cause;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 core_clk = ~core_clk;   // 125 MHz
   always #5 bus_clk  = ~bus_clk;

   rst_fanout_ctrl u_rst_fanout_ctrl (
      .core_clk(core_clk), .bus_clk(bus_clk), .fund_rst_n(fund_rst_n),
      .pwr_exit(pwr_exit), .hot_rst_msg(hot_rst_msg), .link_state(link_state),
      .cause_clr_we(cause_clr_we), .cause_clr_mask(cause_clr_mask),
      .bus_rst_n(bus_rst_n), .core_rst_n(core_rst_n), .rst_cause(rst_cause)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge core_clk);
   endtask

   task automatic clear_all();
      cause_clr_we = 1'b1; cause_clr_mask = 4'hF;
      tick(1);
      cause_clr_we = 1'b0; cause_clr_mask = 4'h0;
   endtask

   // {pwr, hot, link_state[3:0], expect_fire, expect_cause[3:0]}
   localparam int NVEC = 9;
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 4'h7, 1'b0, 4'b0000},  // active, idle
      {1'b0, 1'b1, 4'h7, 1'b1, 4'b0100},  // hot message
      {1'b1, 1'b0, 4'h7, 1'b1, 4'b0010},  // power exit
      {1'b0, 1'b0, 4'h1, 1'b1, 4'b1000},  // active -> Detect
      {1'b0, 1'b0, 4'h1, 1'b0, 4'b0000},  // stay in Detect
      {1'b0, 1'b0, 4'h2, 1'b0, 4'b0000},  // Detect -> Polling
      {1'b0, 1'b0, 4'h7, 1'b0, 4'b0000},  // back to active
      {1'b1, 1'b1, 4'h2, 1'b1, 4'b1110},  // three sources at once
      {1'b0, 1'b0, 4'h7, 1'b0, 4'b0000}   // leave Polling
   };

   initial begin
      // reset state with the pin held
      tick(4);
      chk("R1 bus held", bus_rst_n, 1'b0);
      chk("R3 core held", core_rst_n, 1'b0);
      chk("R11 cause zero", rst_cause, 4'h0);

      // release: bus and core timing side by side
      fund_rst_n = 1'b1;
      fork
         begin
            @(posedge bus_clk); #1;
            chk("R2 bus still low after 1 edge", bus_rst_n, 1'b0);
            @(posedge bus_clk); #1;
            chk("R2 bus high after 2 edges", bus_rst_n, 1'b1);
         end
         begin
            tick(18);
            chk("R4 core low after 18 edges", core_rst_n, 1'b0);
            tick(1);
            chk("R4 core high after 19 edges", core_rst_n, 1'b1);
         end
      join
      chk("R9 pin cause", rst_cause, 4'b0001);
      clear_all();
      chk("R10 full clear", rst_cause, 4'h0);

      // vector walk
      for (int v = 0; v < NVEC; v++) begin
         pwr_exit    = VEC[v][10];
         hot_rst_msg = VEC[v][9];
         link_state  = VEC[v][8:5];
         tick(1);
         chk($sformatf("R5/R6/R7 fire vec %0d", v), core_rst_n, !VEC[v][4]);
         chk($sformatf("R2 bus unaffected vec %0d", v), bus_rst_n, 1'b1);
         pwr_exit = 1'b0; hot_rst_msg = 1'b0;
         tick(18);
         chk($sformatf("R8 single stretch ends vec %0d", v), core_rst_n, 1'b1);
         chk($sformatf("R9 cause vec %0d", v), rst_cause, {28'h0, VEC[v][3:0]});
         clear_all();
      end

      // R5 exact length
      hot_rst_msg = 1'b1; tick(1); hot_rst_msg = 1'b0;
      tick(15);
      chk("R5 low on 16th cycle", core_rst_n, 1'b0);
      tick(1);
      chk("R5 high after 16 cycles", core_rst_n, 1'b1);
      clear_all();

      // R8 retrigger mid-stretch
      hot_rst_msg = 1'b1; tick(1); hot_rst_msg = 1'b0;
      tick(9);
      pwr_exit = 1'b1; tick(1); pwr_exit = 1'b0;
      tick(15);
      chk("R8 still low after restart", core_rst_n, 1'b0);
      tick(1);
      chk("R8 release 16 after retrigger", core_rst_n, 1'b1);
      chk("R9 both causes", rst_cause, 4'b0110);

      // R10 partial clear, then set beats clear
      cause_clr_we = 1'b1; cause_clr_mask = 4'b0010;
      tick(1);
      cause_clr_we = 1'b0; cause_clr_mask = 4'h0;
      chk("R10 partial clear", rst_cause, 4'b0100);
      cause_clr_we = 1'b1; cause_clr_mask = 4'hF; hot_rst_msg = 1'b1;
      tick(1);
      cause_clr_we = 1'b0; cause_clr_mask = 4'h0; hot_rst_msg = 1'b0;
      chk("R10 set wins over clear", rst_cause, 4'b0100);
      tick(18);
      clear_all();

      // pin reasserted mid-run
      fund_rst_n = 1'b0;
      #1;
      chk("R1 async bus assert", bus_rst_n, 1'b0);
      chk("R3 async core assert", core_rst_n, 1'b0);
      tick(2);
      hot_rst_msg = 1'b1; tick(1); hot_rst_msg = 1'b0;
      tick(2);
      chk("R11 held zero", rst_cause, 4'h0);
      fund_rst_n = 1'b1;
      tick(20);
      chk("R11 no in-band record while held", rst_cause, 4'b0001);
      chk("R4 core released", core_rst_n, 1'b1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge core_clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule